// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns one IEEE-754 binary32 word into the nearest IEEE-754 binary16 word. It rounds to nearest, with ties going to the even result. It sits in a datapath where wide floating-point samples must be narrowed before storage or transport. The block takes one word per clock, qualified by a valid strobe, and presents the converted word together with a matching valid strobe exactly one clock later.

A magnitude classifier sorts every input into one of four cases: NaN, overflow, subnormal result or normal result. It does this with straight compares of the 31-bit magnitude against fixed binary32 limits. Two separate arithmetic paths then build the normal and the subnormal encodings. In both paths a round-up is allowed to carry from the mantissa into the exponent field. The sign travels around all of this logic untouched.

Top module: `f2h_convert`

## Requirements
- R1: Output bit 15 equals input bit 31 for every converted word, including zeros, infinities and NaNs.
- R2: An input whose bits 30:0 are all zero produces a zero result with the input's sign (0x0000 or 0x8000).
- R3: A non-NaN input whose magnitude (bits 30:0) is 0x477FF000 or larger produces infinity: bits 14:10 = 0x1F and bits 9:0 = 0. This includes binary32 infinity.
- R4: An input with bits 30:23 all ones and a nonzero bits 22:0 produces a NaN whose bits 14:0 are 0x7E00 ORed with input bits 22:13.
- R5: For a normal result, bits 14:10 are the input exponent field minus 112, and bits 9:0 are input bits 22:13, whenever input bits 12:0 are below 0x1000.
- R6: On the normal path, one is added to the packed 15-bit magnitude when input bits 12:0 exceed 0x1000, or equal 0x1000 while input bit 13 is 1. A carry out of the mantissa increments the exponent (for example 0x3FFFF000 gives 0x4000).
- R7: A magnitude below 0x477FF000 never gives exponent field 0x1F. The largest finite result is 0x7BFF, which input 0x477FE000 (65504) produces.
- R8: A magnitude below 0x38800000 takes the subnormal path. The 24-bit significand (hidden one restored when the exponent field is nonzero) is shifted right by 126 minus the exponent field. The shifted-out bits are then rounded to nearest, ties to even.
- R9: On the subnormal path, a round-up from 0x3FF yields 0x0400 (input 0x387FE000 gives 0x0400). A value of at most half the smallest subnormal yields zero (0x33000000 gives 0x0000). A value just above that half yields 0x0001.
- R10: out_valid is in_valid delayed by one clock. out_f16 loads only on a clock edge where in_valid is 1 and otherwise holds its value. A synchronous active-high rst clears both out_valid and out_f16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_f32 | input | 32 | binary32 operand |
| out_valid | output | 1 | Result qualifier, one clock after in_valid |
| out_f16 | output | 16 | binary16 result |

## Verification
The hardest cases to reach are inputs that lie exactly on a rounding tie. In the subnormal path the tie bit moves with the exponent, and a round-up can push a value across the subnormal-to-normal boundary or into the exponent. Uniform random words almost never land there. The stimulus therefore places exact half-way patterns by hand at the boundary values (0x387FE000, 0x33000000, 0x3FFFF000, 0x477FF000), and confines half of the random exponents to the band around the half-precision range. The bench's reference computes each result as a scaled integer quotient with an explicit remainder compare, which is a different route from the design's bit-slice rounding.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_MAN_W  = 10;
  localparam int MAG_W     = SP_W - 1;
  localparam int HMAG_W    = HP_W - 1;
  localparam int DROP_W    = SP_MAN_W - HP_MAN_W;
  localparam int SIG_W     = SP_MAN_W + 1;
  localparam int WIDE_W    = 2 * SIG_W;
  localparam int SP_BIAS   = 127;
  localparam int HP_BIAS   = 15;
  localparam int REBIAS    = SP_BIAS - HP_BIAS;
  localparam int SUB_SHIFT_BASE = SP_BIAS - 1;
  localparam int SUB_SHIFT_CAP  = SIG_W + 1;

  localparam logic [MAG_W-1:0]  OVF_LIMIT = 31'h477F_F000;
  localparam logic [MAG_W-1:0]  SUB_LIMIT = 31'h3880_0000;
  localparam logic [DROP_W-1:0] DROP_HALF = 13'h1000;
  localparam logic [HMAG_W-1:0] HP_INF    = 15'h7C00;
  localparam logic [HMAG_W-1:0] HP_QNAN   = 15'h7E00;

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } f2h_cls_e;

  // Normal result: rebias, truncate, then round the packed magnitude so
  // that a mantissa carry ripples into the exponent field.
  function automatic logic [HMAG_W-1:0] pack_normal(
    input logic [SP_EXP_W-1:0] e,
    input logic [SP_MAN_W-1:0] m
  );
    logic [HP_EXP_W-1:0] he;
    logic [DROP_W-1:0]   drop;
    logic [HMAG_W-1:0]   base;
    logic                up;
    he   = HP_EXP_W'(e - SP_EXP_W'(REBIAS));
    drop = m[DROP_W-1:0];
    base = {he, m[SP_MAN_W-1:DROP_W]};
    up   = (drop > DROP_HALF) || ((drop == DROP_HALF) && m[DROP_W]);
    return base + HMAG_W'(up);
  endfunction

  // Subnormal result: align the significand to the 2^-24 grid, then round
  // on the round bit and the OR of everything below it.
  function automatic logic [HMAG_W-1:0] pack_subnormal(
    input logic [SP_EXP_W-1:0] e,
    input logic [SP_MAN_W-1:0] m
  );
    logic [SP_EXP_W-1:0] sh_raw;
    logic [SP_EXP_W-1:0] sh;
    logic [WIDE_W-1:0]   wide;
    logic [SIG_W-1:0]    kept;
    logic                rbit;
    logic                sticky;
    sh_raw = SP_EXP_W'(SUB_SHIFT_BASE) - e;
    sh     = (sh_raw > SP_EXP_W'(SUB_SHIFT_CAP)) ? SP_EXP_W'(SUB_SHIFT_CAP) : sh_raw;
    wide   = {(e != '0), m, {SIG_W{1'b0}}} >> sh;
    kept   = wide[WIDE_W-1:SIG_W];
    rbit   = wide[SIG_W-1];
    sticky = |wide[SIG_W-2:0];
    return HMAG_W'(kept) + HMAG_W'(rbit & (sticky | kept[0]));
  endfunction

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output f2h_cls_e         cls
);

  logic exp_all_ones;
  logic man_nonzero;

  assign exp_all_ones = &mag[MAG_W-1:SP_MAN_W];
  assign man_nonzero  = |mag[SP_MAN_W-1:0];

  always_comb begin
    if (exp_all_ones && man_nonzero) cls = CLS_NAN;
    else if (mag >= OVF_LIMIT)       cls = CLS_INF;
    else if (mag < SUB_LIMIT)        cls = CLS_SUB;
    else                             cls = CLS_NORM;
  end

endmodule

// File: rtl/f2h_normal_path.sv
module f2h_normal_path
  import f2h_pkg::*;
(
  input  logic [SP_EXP_W-1:0] exp_in,
  input  logic [SP_MAN_W-1:0] man_in,
  output logic [HMAG_W-1:0]   mag_out
);

  assign mag_out = pack_normal(exp_in, man_in);

endmodule

// File: rtl/f2h_subnormal_path.sv
module f2h_subnormal_path
  import f2h_pkg::*;
(
  input  logic [SP_EXP_W-1:0] exp_in,
  input  logic [SP_MAN_W-1:0] man_in,
  output logic [HMAG_W-1:0]   mag_out
);

  assign mag_out = pack_subnormal(exp_in, man_in);

endmodule

// File: rtl/f2h_convert.sv
module f2h_convert
  import f2h_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_f32,
  output logic            out_valid,
  output logic [HP_W-1:0] out_f16
);

  logic [MAG_W-1:0]    in_mag;
  logic [SP_EXP_W-1:0] in_exp;
  logic [SP_MAN_W-1:0] in_man;
  logic                in_sign;
  f2h_cls_e            cls;
  logic [HMAG_W-1:0]   norm_mag;
  logic [HMAG_W-1:0]   sub_mag;
  logic [HMAG_W-1:0]   nan_mag;
  logic [HMAG_W-1:0]   res_mag;

  assign in_sign = in_f32[SP_W-1];
  assign in_mag  = in_f32[MAG_W-1:0];
  assign in_exp  = in_f32[MAG_W-1:SP_MAN_W];
  assign in_man  = in_f32[SP_MAN_W-1:0];

  f2h_classify u_cls (
    .mag (in_mag),
    .cls (cls)
  );

  f2h_normal_path u_norm (
    .exp_in  (in_exp),
    .man_in  (in_man),
    .mag_out (norm_mag)
  );

  f2h_subnormal_path u_sub (
    .exp_in  (in_exp),
    .man_in  (in_man),
    .mag_out (sub_mag)
  );

  assign nan_mag = HP_QNAN | HMAG_W'(in_man[SP_MAN_W-1:DROP_W]);

  always_comb begin
    unique case (cls)
      CLS_NAN:  res_mag = nan_mag;
      CLS_INF:  res_mag = HP_INF;
      CLS_SUB:  res_mag = sub_mag;
      default:  res_mag = norm_mag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_f16   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_f16 <= {in_sign, res_mag};
    end
  end

  // R10: valid is a one-clock delay of in_valid
  a_r10_valid_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R10: data holds when nothing was accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_f16));

  // R1: sign passes straight through
  a_r1_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (out_f16[HP_W-1] == $past(in_f32[SP_W-1])));

  // R2: signed zero
  a_r2_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_f32[MAG_W-1:0]) == '0))
    |-> (out_f16[HMAG_W-1:0] == '0));

  // R3: overflow gives infinity
  a_r3_overflow_inf: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_f32[MAG_W-1:0]) >= OVF_LIMIT)
     && !(($past(in_f32[MAG_W-1:SP_MAN_W]) == '1) && ($past(in_f32[SP_MAN_W-1:0]) != '0)))
    |-> (out_f16[HMAG_W-1:0] == HP_INF));

  // R4: NaN stays NaN with the quiet bit set
  a_r4_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_f32[MAG_W-1:SP_MAN_W]) == '1)
     && ($past(in_f32[SP_MAN_W-1:0]) != '0))
    |-> ((out_f16[HMAG_W-1:HP_MAN_W] == '1) && out_f16[HP_MAN_W-1]));

  // R7: in-range magnitudes never saturate
  a_r7_no_false_inf: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_f32[MAG_W-1:0]) < OVF_LIMIT))
    |-> (out_f16[HMAG_W-1:HP_MAN_W] != '1));

  // R8: the subnormal band never reaches beyond the smallest normal
  a_r8_sub_bound: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_f32[MAG_W-1:0]) < SUB_LIMIT))
    |-> (out_f16[HMAG_W-1:0] <= 15'h0400));

endmodule

// File: tb/f2h_convert_tb.sv
`timescale 1ns/1ps
module f2h_convert_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_f32 = '0;
  logic        out_valid;
  logic [15:0] out_f16;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] last_exp = '0;

  always #4 clk = ~clk;

  f2h_convert dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_f32    (in_f32),
    .out_valid (out_valid),
    .out_f16   (out_f16)
  );

  // Reference: value = sig * 2^(E-150); count it in units of the target
  // half-precision quantum and round the integer quotient by remainder.
  function automatic logic [15:0] ref_h(input logic [31:0] x);
    int     e, he, s;
    longint sig, q, rem, half;
    e = int'(x[30:23]);
    if (e == 255 && x[22:0] != 0)
      return {x[31], 15'h7E00 | 15'(x[22:13])};
    if (x[30:0] >= 31'h477F_F000)
      return {x[31], 15'h7C00};
    if (e == 0) begin
      sig = longint'(x[22:0]);
      e = 1;
    end else begin
      sig = longint'({1'b1, x[22:0]});
    end
    he = e - 127;
    if (he < -14) he = -14;
    s = he + 140 - e;
    if (s > 40) begin
      q = 0;
    end else begin
      q    = sig >> s;
      rem  = sig - (q << s);
      half = longint'(1) << (s - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
    end
    return {x[31], 15'((longint'(he + 14) << 10) + q)};
  endfunction

  function automatic string cls_tag(input logic [31:0] x);
    if (x[30:23] == 8'hFF && x[22:0] != 0) return "R4";
    if (x[30:0] >= 31'h477F_F000)          return "R3";
    if (x[30:0] == 0)                      return "R2";
    if (x[30:0] < 31'h3880_0000)           return "R8";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic v, input string tag);
    in_f32   = w;
    in_valid = v;
    @(posedge clk);
    #2;
    chk("R10 valid", {15'd0, out_valid}, {15'd0, v});
    if (v) begin
      last_exp = ref_h(w);
      chk(tag, out_f16, last_exp);
      chk("R1 sign", {15'd0, out_f16[15]}, {15'd0, w[31]});
    end else begin
      chk("R10 hold", out_f16, last_exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset valid", {15'd0, out_valid}, 16'h0000);
    chk("R10 reset data", out_f16, 16'h0000);
    rst = 1'b0;

    apply(32'h0000_0000, 1, "R2");
    apply(32'h8000_0000, 1, "R2");
    apply(32'h3F80_0000, 1, "R5");
    apply(32'hC0A0_0000, 1, "R5");
    apply(32'h3F80_1000, 1, "R6");
    apply(32'h3F80_3000, 1, "R6");
    apply(32'h3F80_1001, 1, "R6");
    apply(32'h3FFF_F000, 1, "R6");
    chk("R6 carry", out_f16, 16'h4000);
    apply(32'h477F_E000, 1, "R7");
    chk("R7 max", out_f16, 16'h7BFF);
    apply(32'h477F_EFFF, 1, "R7");
    apply(32'h477F_F000, 1, "R3");
    apply(32'h7F80_0000, 1, "R3");
    apply(32'hFF80_0000, 1, "R3");
    apply(32'h7FC0_0000, 1, "R4");
    apply(32'h7F80_0001, 1, "R4");
    apply(32'hFFFF_FFFF, 1, "R4");
    apply(32'h387F_E000, 1, "R9");
    chk("R9 roll", out_f16, 16'h0400);
    apply(32'h3880_0000, 1, "R8");
    apply(32'h3380_0000, 1, "R8");
    apply(32'h3300_0000, 1, "R9");
    chk("R9 tie low", out_f16, 16'h0000);
    apply(32'h3300_0001, 1, "R9");
    apply(32'h3540_0000, 1, "R8");
    apply(32'h0000_0001, 1, "R8");
    apply(32'h1234_5678, 0, "R10");
    apply(32'hB8C0_0000, 0, "R10");

    in_f32   = 32'h3F80_0000;
    in_valid = 1'b1;
    rst      = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 mid reset valid", {15'd0, out_valid}, 16'h0000);
    chk("R10 mid reset data", out_f16, 16'h0000);
    rst = 1'b0;
    last_exp = '0;

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic        v;
      w = $urandom;
      if (i % 2 == 0) w[30:23] = 8'(100 + ($urandom % 46));
      if (i % 17 == 0) w[12:0] = 13'h1000;
      v = ($urandom % 5) != 0;
      apply(w, v, cls_tag(w));
    end

    finish_run();
  end

endmodule